// File: doc/BRIEF.md
# Fast-to-Slow Bus Bridge with Video Write Shadowing

This block sits between a fast CPU bus and a slower bus that carries legacy peripherals and video memory. Every CPU cycle presents a 24-bit address: an 8-bit bank and a 16-bit offset. The bridge decodes it and decides where the cycle goes. Most cycles complete in the same clock on the fast memory side. Cycles to the two slow video banks ($E0 and $E1) and to the I/O page of the two low banks are carried out on a buffered 16-bit address, 8-bit data slow bus. While such a cycle runs, `cpu_ready` is held low.

The slow clock appears in the fast domain as a one-cycle enable pulse, `slow_ce`. A slow access waits for the first pulse after it is accepted and then occupies the slow bus until the next pulse. When shadowing is on, writes to the video windows of banks $00 and $01 complete in fast RAM and are also replayed as slow writes to banks $E0 and $E1. The bridge keeps its own copy of three soft switches, because they change how fast-side accesses map: auxiliary-bank select, language-card RAM enable and shadow enable. It also inserts fast-RAM refresh cycles ahead of CPU cycles.

Top module: `bus_bridge`

## Requirements
- R1: During reset and after it, with no request and no refresh pending, `cpu_ready`=1 and `sb_act`, `fast_rfsh` and `fast_cyc` are all 0. Reset clears the auxiliary, language-card and shadow switches.
- R2: Any cycle to bank $E0 or $E1 goes to the slow bus and never asserts `fast_cyc`. `sb_addr` equals the offset, `sb_hibank` equals bank bit 0, and `sb_we`/`sb_wdata` follow the CPU.
- R3: A cycle to offsets $C000-$CFFF of bank $00 or $01 goes to the slow bus only, with `sb_hibank` equal to bank bit 0. The same offsets in any other bank are ordinary fast cycles.
- R4: Any other cycle asserts `fast_cyc` and `cpu_ready` in the cycle the request is presented. `cpu_rdata` equals `fast_rdata` in that cycle.
- R5: A slow access starts on the first `slow_ce` pulse after the accept cycle. `sb_act` is high from the next cycle through the cycle of the following pulse, which is 3 cycles at one pulse every 3 cycles. `cpu_ready` rises for one cycle after that. `cpu_rdata` then holds `sb_rdata` as sampled on the second pulse.
- R6: With shadowing on, a write to bank $00 or $01 at an offset in $0400-$0BFF or $2000-$5FFF (bounds inclusive) does both of these: it asserts `fast_cyc` with the unchanged bank in the request cycle, and it performs a slow write to the same offset with `sb_hibank` equal to bank bit 0, stalling as in R5.
- R7: Reads from banks $00 and $01 outside the I/O page never use the slow bus. Writes to the video windows are fast-only while shadowing is off.
- R8: A write to offset $C036 of bank $00 or $01 loads the shadow enable from `cpu_wdata` bit 0.
- R9: A write to offset $C005 of bank $00/$01 sets the auxiliary switch, and a write to $C004 clears it. While the switch is set, fast accesses to bank $00 at offsets $0200-$BFFF appear on `fast_addr` in bank $01.
- R10: Any access to offsets $C080-$C08F of bank $00/$01 sets the language-card enable to offset bit 0. While it is 0, fast accesses to bank $00/$01 at offsets $D000-$FFFF appear on `fast_addr` in bank $FF. While it is 1, they keep their bank.
- R11: When the bridge is idle and a refresh is pending, or `rfsh_req` is high, `fast_rfsh` is 1 for that one cycle. No CPU cycle is accepted in that cycle (`cpu_ready`=0, `fast_cyc`=0), and the CPU cycle is accepted in the next cycle.
- R12: A `rfsh_req` pulse that arrives during a slow access is held. `fast_rfsh` stays 0 until that access has completed, and then becomes 1 for one cycle in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU cycle request, held until `cpu_ready` |
| cpu_we | input | 1 | CPU write |
| cpu_addr | input | 24 | Bank (23:16) and offset (15:0) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data to the CPU |
| cpu_ready | output | 1 | Cycle completes at this clock edge |
| fast_cyc | output | 1 | Fast memory access strobe |
| fast_we | output | 1 | Fast memory write |
| fast_addr | output | 24 | Mapped fast memory address |
| fast_rdata | input | 8 | Fast memory read data |
| fast_rfsh | output | 1 | Fast RAM refresh cycle |
| rfsh_req | input | 1 | Refresh request pulse |
| slow_ce | input | 1 | Slow clock enable pulse |
| sb_act | output | 1 | Slow bus data phase active |
| sb_we | output | 1 | Slow bus write |
| sb_hibank | output | 1 | Slow bank select: 0 = $E0, 1 = $E1 |
| sb_addr | output | 16 | Slow bus address |
| sb_wdata | output | 8 | Slow bus write data |
| sb_rdata | input | 8 | Slow bus read data |

## Verification
The assertions assume that the CPU holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady from the cycle a request appears until the edge where `cpu_ready` is seen. They also assume that `slow_ce` is a single-cycle pulse spaced at least two cycles apart. The stimulus changes CPU inputs only on falling edges, and only after a completing edge. It generates `slow_ce` from a free-running divide-by-three counter and drives `rfsh_req` as isolated one-cycle pulses.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int BANK_W = 8;
  localparam int OFS_W  = 16;
  localparam int DAT_W  = 8;
  localparam int ADR_W  = BANK_W + OFS_W;
  localparam int NWIN   = 2;

  localparam logic [OFS_W-1:0] WIN_LO [NWIN] = '{16'h0400, 16'h2000};
  localparam logic [OFS_W-1:0] WIN_HI [NWIN] = '{16'h0BFF, 16'h5FFF};

  localparam logic [BANK_W-2:0] SLOW_BANK_PAIR = 7'h70; // $E0/$E1
  localparam logic [BANK_W-1:0] ROM_BANK       = 8'hFF;
  localparam logic [OFS_W-1:0]  AUX_LO         = 16'h0200;
  localparam logic [OFS_W-1:0]  AUX_HI         = 16'hBFFF;
  localparam logic [OFS_W-1:0]  LC_LO          = 16'hD000;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SLOW, S_DONE} seq_st_e;
endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
  import bridge_pkg::*;
(
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              aux_on,
  input  logic              lc_on,
  input  logic              shadow_on,
  output logic              need_slow,
  output logic              need_fast,
  output logic              io_hit,
  output logic [ADR_W-1:0]  map_addr
);
  logic ebank, lowbank, vid_hit;
  logic [NWIN-1:0] win_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NWIN; gi++) begin : g_win
      assign win_hit[gi] = (ofs >= WIN_LO[gi]) && (ofs <= WIN_HI[gi]);
    end
  endgenerate

  always_comb begin
    ebank   = (bank[BANK_W-1:1] == SLOW_BANK_PAIR);
    lowbank = (bank[BANK_W-1:1] == '0);
    io_hit  = lowbank && (ofs[OFS_W-1:OFS_W-4] == 4'hC);
    vid_hit = lowbank && (|win_hit);
    need_slow = cpu_req && (ebank || io_hit || (vid_hit && cpu_we && shadow_on));
    need_fast = cpu_req && !ebank && !io_hit;
    map_addr = {bank, ofs};
    if ((bank == '0) && aux_on && (ofs >= AUX_LO) && (ofs <= AUX_HI))
      map_addr[ADR_W-1:OFS_W] = 8'h01;
    else if (lowbank && !lc_on && (ofs >= LC_LO))
      map_addr[ADR_W-1:OFS_W] = ROM_BANK;
  end
endmodule

// File: rtl/bridge_switches.sv
module bridge_switches (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        io_hit,
  input  logic        cpu_we,
  input  logic [11:0] io_ofs,
  input  logic        wbit,
  output logic        aux_on,
  output logic        lc_on,
  output logic        shadow_on
);
  logic aux_d, lc_d, sh_d, sw_page;

  always_comb begin
    aux_d   = aux_on;
    lc_d    = lc_on;
    sh_d    = shadow_on;
    sw_page = go && io_hit && (io_ofs[11:8] == 4'h0);
    if (sw_page) begin
      if (cpu_we && io_ofs[7:0] == 8'h04) aux_d = 1'b0;
      if (cpu_we && io_ofs[7:0] == 8'h05) aux_d = 1'b1;
      if (cpu_we && io_ofs[7:0] == 8'h36) sh_d  = wbit;
      if (io_ofs[7:4] == 4'h8)            lc_d  = io_ofs[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_on    <= 1'b0;
      lc_on     <= 1'b0;
      shadow_on <= 1'b0;
    end else begin
      aux_on    <= aux_d;
      lc_on     <= lc_d;
      shadow_on <= sh_d;
    end
  end

  AST_SWITCH_ONLY_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(go) |-> ($stable(aux_on) && $stable(lc_on) && $stable(shadow_on))) // R8
    else $error("switch changed without an accepted cycle");
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              need_slow,
  input  logic              need_fast,
  input  logic              hib_in,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DAT_W-1:0]  wdata,
  input  logic              rfsh_req,
  input  logic              slow_ce,
  input  logic [DAT_W-1:0]  sb_rdata,
  input  logic [DAT_W-1:0]  fast_rdata,
  output logic              go,
  output logic              cpu_ready,
  output logic [DAT_W-1:0]  cpu_rdata,
  output logic              fast_cyc,
  output logic              fast_rfsh,
  output logic              sb_act,
  output logic              sb_we,
  output logic              sb_hibank,
  output logic [OFS_W-1:0]  sb_addr,
  output logic [DAT_W-1:0]  sb_wdata
);
  seq_st_e st_q, st_d;
  logic pend_q, pend_d, rf, idle, go_slow;
  logic [DAT_W-1:0] rd_q, rd_d;
  logic lat_we_q, lat_hib_q;
  logic [OFS_W-1:0] lat_ofs_q;
  logic [DAT_W-1:0] lat_wd_q;

  always_comb begin
    idle      = (st_q == S_IDLE);
    rf        = pend_q || rfsh_req;
    fast_rfsh = idle && rf;
    go_slow   = idle && !rf && cpu_req && need_slow;
    fast_cyc  = idle && !rf && cpu_req && need_fast;
    go        = go_slow || fast_cyc;
    cpu_ready = (idle && !rf && !need_slow) || (st_q == S_DONE);
    cpu_rdata = (st_q == S_DONE) ? rd_q : fast_rdata;
    pend_d    = (pend_q || rfsh_req) && !fast_rfsh;
    rd_d      = rd_q;
    st_d      = st_q;
    unique case (st_q)
      S_IDLE: if (go_slow) st_d = S_WAIT;
      S_WAIT: if (slow_ce) st_d = S_SLOW;
      S_SLOW: if (slow_ce) begin
                st_d = S_DONE;
                rd_d = sb_rdata;
              end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      pend_q    <= 1'b0;
      rd_q      <= '0;
      lat_we_q  <= 1'b0;
      lat_hib_q <= 1'b0;
      lat_ofs_q <= '0;
      lat_wd_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      rd_q   <= rd_d;
      if (go_slow) begin
        lat_we_q  <= cpu_we;
        lat_hib_q <= hib_in;
        lat_ofs_q <= ofs;
        lat_wd_q  <= wdata;
      end
    end
  end

  assign sb_act    = (st_q == S_SLOW);
  assign sb_we     = lat_we_q;
  assign sb_hibank = lat_hib_q;
  assign sb_addr   = lat_ofs_q;
  assign sb_wdata  = lat_wd_q;

  AST_SLOW_STARTS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_act) |-> $past(slow_ce)) // R5
    else $error("slow phase began without a pulse");
  AST_DONE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DONE) |-> ($past(slow_ce) && $past(sb_act))) // R5
    else $error("slow phase ended without a pulse");
  AST_SB_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_act && $past(sb_act)) |-> ($stable(sb_addr) && $stable(sb_we))) // R5
    else $error("slow address moved during data phase");
  AST_RFSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !idle) |=> pend_q) // R12
    else $error("refresh request lost during slow access");
  AST_RFSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_rfsh && !rfsh_req) |=> !fast_rfsh || $past(rfsh_req)) // R11
    else $error("refresh repeated without request");
endmodule

// File: rtl/bus_bridge.sv
module bus_bridge
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADR_W-1:0]  cpu_addr,
  input  logic [DAT_W-1:0]  cpu_wdata,
  output logic [DAT_W-1:0]  cpu_rdata,
  output logic              cpu_ready,
  output logic              fast_cyc,
  output logic              fast_we,
  output logic [ADR_W-1:0]  fast_addr,
  input  logic [DAT_W-1:0]  fast_rdata,
  output logic              fast_rfsh,
  input  logic              rfsh_req,
  input  logic              slow_ce,
  output logic              sb_act,
  output logic              sb_we,
  output logic              sb_hibank,
  output logic [OFS_W-1:0]  sb_addr,
  output logic [DAT_W-1:0]  sb_wdata,
  input  logic [DAT_W-1:0]  sb_rdata
);
  logic [1:0] rst_sync;
  logic rst_i_n;
  logic aux_on, lc_on, shadow_on, need_slow, need_fast, io_hit, go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  bridge_decode u_dec (
    .cpu_req(cpu_req), .cpu_we(cpu_we),
    .bank(cpu_addr[ADR_W-1:OFS_W]), .ofs(cpu_addr[OFS_W-1:0]),
    .aux_on(aux_on), .lc_on(lc_on), .shadow_on(shadow_on),
    .need_slow(need_slow), .need_fast(need_fast), .io_hit(io_hit),
    .map_addr(fast_addr)
  );

  bridge_switches u_sw (
    .clk(clk), .rst_n(rst_i_n), .go(go), .io_hit(io_hit), .cpu_we(cpu_we),
    .io_ofs(cpu_addr[11:0]), .wbit(cpu_wdata[0]),
    .aux_on(aux_on), .lc_on(lc_on), .shadow_on(shadow_on)
  );

  bridge_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .need_slow(need_slow), .need_fast(need_fast), .hib_in(cpu_addr[OFS_W]),
    .ofs(cpu_addr[OFS_W-1:0]), .wdata(cpu_wdata), .rfsh_req(rfsh_req),
    .slow_ce(slow_ce), .sb_rdata(sb_rdata), .fast_rdata(fast_rdata),
    .go(go), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .fast_cyc(fast_cyc), .fast_rfsh(fast_rfsh), .sb_act(sb_act),
    .sb_we(sb_we), .sb_hibank(sb_hibank), .sb_addr(sb_addr), .sb_wdata(sb_wdata)
  );

  assign fast_we = fast_cyc && cpu_we;

  AST_EBANK_NEVER_FAST: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_req && cpu_addr[ADR_W-1:OFS_W+1] == SLOW_BANK_PAIR) |-> !fast_cyc) // R2
    else $error("slow bank reached fast memory");
  AST_SHADOW_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fast_cyc && !cpu_ready) |-> cpu_we) // R7
    else $error("stalled fast cycle that is not a write");
  AST_RFSH_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_i_n)
    fast_rfsh |-> (!fast_cyc && !cpu_ready)) // R11
    else $error("CPU served during refresh");
endmodule

// File: tb/sim_bus_bridge.sv
module sim_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic        we;
    logic [7:0]  bank;
    logic [15:0] ofs;
    logic [7:0]  wd;
    logic        slow;
    logic        fast;
    logic [7:0]  fbank;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 16'h1234, 8'h00, 1'b0, 1'b1, 8'h00, 8'd4},  // R4 plain fast read
    '{1'b0, 8'hE0, 16'h0400, 8'h00, 1'b1, 1'b0, 8'h00, 8'd2},  // R2 slow read E0
    '{1'b1, 8'hE1, 16'h2000, 8'h5A, 1'b1, 1'b0, 8'h00, 8'd2},  // R2 slow write E1
    '{1'b0, 8'h01, 16'hC030, 8'h00, 1'b1, 1'b0, 8'h00, 8'd3},  // R3 I/O read bank 01
    '{1'b1, 8'h00, 16'h0400, 8'hA5, 1'b0, 1'b1, 8'h00, 8'd7},  // R7 shadow off
    '{1'b1, 8'h00, 16'hC036, 8'h01, 1'b1, 1'b0, 8'h00, 8'd8},  // R8 shadow on
    '{1'b1, 8'h00, 16'h0400, 8'h77, 1'b1, 1'b1, 8'h00, 8'd6},  // R6 low edge
    '{1'b1, 8'h01, 16'h2100, 8'h33, 1'b1, 1'b1, 8'h01, 8'd6},  // R6 bank 01
    '{1'b0, 8'h01, 16'h2100, 8'h00, 1'b0, 1'b1, 8'h01, 8'd7},  // R7 read no slow
    '{1'b1, 8'h00, 16'h0C00, 8'h11, 1'b0, 1'b1, 8'h00, 8'd6},  // R6 outside window
    '{1'b1, 8'h00, 16'h5FFF, 8'h22, 1'b1, 1'b1, 8'h00, 8'd6},  // R6 high edge
    '{1'b1, 8'h00, 16'hC005, 8'h00, 1'b1, 1'b0, 8'h00, 8'd9},  // R9 aux on
    '{1'b0, 8'h00, 16'h0300, 8'h00, 1'b0, 1'b1, 8'h01, 8'd9},  // R9 remapped
    '{1'b0, 8'h00, 16'h01FF, 8'h00, 1'b0, 1'b1, 8'h00, 8'd9},  // R9 below range
    '{1'b0, 8'h00, 16'hD000, 8'h00, 1'b0, 1'b1, 8'hFF, 8'd10}, // R10 lc off
    '{1'b0, 8'h00, 16'hC081, 8'h00, 1'b1, 1'b0, 8'h00, 8'd10}, // R10 lc on
    '{1'b0, 8'h00, 16'hD000, 8'h00, 1'b0, 1'b1, 8'h00, 8'd10}, // R10 lc ram
    '{1'b1, 8'h00, 16'hC004, 8'h00, 1'b1, 1'b0, 8'h00, 8'd9},  // R9 aux off
    '{1'b0, 8'h00, 16'h0300, 8'h00, 1'b0, 1'b1, 8'h00, 8'd9},  // R9 back to main
    '{1'b0, 8'h02, 16'hC000, 8'h00, 1'b0, 1'b1, 8'h02, 8'd3},  // R3 not I/O in bank 02
    '{1'b1, 8'h01, 16'hC036, 8'h00, 1'b1, 1'b0, 8'h00, 8'd8},  // R8 shadow off
    '{1'b1, 8'h00, 16'h0400, 8'h44, 1'b0, 1'b1, 8'h00, 8'd8}   // R8 no copy now
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0, rfsh_req = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata, fast_rdata, sb_rdata, sb_wdata;
  logic cpu_ready, fast_cyc, fast_we, fast_rfsh, sb_act, sb_we, sb_hibank, slow_ce;
  logic [23:0] fast_addr;
  logic [15:0] sb_addr;
  logic [1:0] ce_cnt = 2'd0;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ce_cnt <= (ce_cnt == 2'd2) ? 2'd0 : ce_cnt + 2'd1;
  assign slow_ce    = (ce_cnt == 2'd2);
  assign sb_rdata   = sb_addr[7:0] ^ 8'h5A;
  assign fast_rdata = fast_addr[7:0] ^ fast_addr[23:16];

  bus_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .fast_cyc(fast_cyc), .fast_we(fast_we),
    .fast_addr(fast_addr), .fast_rdata(fast_rdata), .fast_rfsh(fast_rfsh),
    .rfsh_req(rfsh_req), .slow_ce(slow_ce), .sb_act(sb_act), .sb_we(sb_we),
    .sb_hibank(sb_hibank), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
    .sb_rdata(sb_rdata)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog (all R) cycles=%0d limit=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  // Present one CPU cycle and follow it to completion.
  task automatic run_cyc(input logic we, input logic [7:0] bank, input logic [15:0] ofs,
                         input logic [7:0] wd, output logic fc0, output logic [23:0] fa0,
                         output logic rdy0, output int pulses, output int act_n,
                         output logic lastce, output logic [15:0] sa, output logic sh,
                         output logic sw, output logic [7:0] swd, output logic [7:0] rd);
    int n;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = {bank, ofs}; cpu_wdata = wd;
    #1;
    fc0 = fast_cyc; fa0 = fast_addr; rdy0 = cpu_ready;
    pulses = 0; act_n = 0; lastce = 1'b0; sa = '0; sh = 1'b0; sw = 1'b0; swd = '0;
    n = 0;
    while (!cpu_ready && n < 40) begin
      @(posedge clk); @(negedge clk); #1;
      n++;
      if (!cpu_ready) begin
        if (slow_ce) pulses++;
        lastce = slow_ce;
        if (sb_act) begin
          act_n++; sa = sb_addr; sh = sb_hibank; sw = sb_we; swd = sb_wdata;
        end
      end
    end
    rd = cpu_rdata;
    @(posedge clk);
  endtask

  initial begin
    logic fc0, rdy0, lastce, sh, sw;
    logic [23:0] fa0;
    logic [15:0] sa;
    logic [7:0] swd, rd;
    int pulses, act_n;
    string tg;

    do_reset();
    @(negedge clk); #1;
    // R1 reset state
    chk(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
    chk(sb_act == 1'b0, "R1 sb_act", sb_act, 0);
    chk(fast_rfsh == 1'b0, "R1 rfsh", fast_rfsh, 0);
    chk(fast_cyc == 1'b0, "R1 fast_cyc", fast_cyc, 0);

    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      tg = $sformatf("R%0d vec%0d", v.rq, i);
      run_cyc(v.we, v.bank, v.ofs, v.wd, fc0, fa0, rdy0, pulses, act_n, lastce, sa, sh, sw, swd, rd);
      chk(fc0 == v.fast, {tg, " fast_cyc"}, fc0, v.fast);
      if (v.fast) chk(fa0 == {v.fbank, v.ofs}, {tg, " fast_addr"}, fa0, {v.fbank, v.ofs});
      chk(rdy0 == !v.slow, {tg, " first ready"}, rdy0, !v.slow);
      if (v.slow) begin
        // R5 stall length and slow-bus contents
        chk(pulses == 2, {tg, " R5 pulses"}, pulses, 2);
        chk(act_n == 3, {tg, " R5 sb_act cycles"}, act_n, 3);
        chk(lastce == 1'b1, {tg, " R5 end on pulse"}, lastce, 1);
        chk(sa == v.ofs, {tg, " sb_addr"}, sa, v.ofs);
        chk(sh == v.bank[0], {tg, " sb_hibank"}, sh, v.bank[0]);
        chk(sw == v.we, {tg, " sb_we"}, sw, v.we);
        if (v.we) chk(swd == v.wd, {tg, " sb_wdata"}, swd, v.wd);
        else      chk(rd == (v.ofs[7:0] ^ 8'h5A), {tg, " R5 rdata"}, rd, v.ofs[7:0] ^ 8'h5A);
      end else begin
        chk(act_n == 0, {tg, " no slow"}, act_n, 0);
        if (!v.we) chk(rd == (v.ofs[7:0] ^ v.fbank), {tg, " R4 rdata"}, rd, v.ofs[7:0] ^ v.fbank);
      end
    end

    // R11: refresh and CPU request together
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 24'h001234; rfsh_req = 1'b1;
    #1;
    chk(fast_rfsh == 1'b1, "R11 rfsh first", fast_rfsh, 1);
    chk(cpu_ready == 1'b0, "R11 cpu waits", cpu_ready, 0);
    chk(fast_cyc == 1'b0, "R11 no fast", fast_cyc, 0);
    @(negedge clk);
    rfsh_req = 1'b0;
    #1;
    chk(fast_rfsh == 1'b0, "R11 rfsh one cycle", fast_rfsh, 0);
    chk(cpu_ready && fast_cyc, "R11 cpu next", {cpu_ready, fast_cyc}, 2'b11);

    // R12: refresh pulse during a slow access
    @(negedge clk);
    cpu_addr = 24'hE00010;
    begin
      int n = 0;
      int rf_seen = 0;
      @(negedge clk);
      rfsh_req = 1'b1;
      #1;
      if (fast_rfsh) rf_seen++;
      @(negedge clk);
      rfsh_req = 1'b0;
      #1;
      while (!cpu_ready && n < 40) begin
        if (fast_rfsh) rf_seen++;
        @(negedge clk); #1; n++;
      end
      chk(rf_seen == 0, "R12 held during slow", rf_seen, 0);
      chk(fast_rfsh == 1'b0, "R12 not in done cycle", fast_rfsh, 0);
      @(negedge clk);
      cpu_req = 1'b0;
      #1;
      chk(fast_rfsh == 1'b1, "R12 served after", fast_rfsh, 1);
      @(negedge clk); #1;
      chk(fast_rfsh == 1'b0, "R12 once", fast_rfsh, 0);
    end

    // R1: switches cleared by a second reset
    run_cyc(1'b1, 8'h00, 16'hC036, 8'h01, fc0, fa0, rdy0, pulses, act_n, lastce, sa, sh, sw, swd, rd);
    run_cyc(1'b1, 8'h00, 16'hC005, 8'h00, fc0, fa0, rdy0, pulses, act_n, lastce, sa, sh, sw, swd, rd);
    cpu_req = 1'b0;
    do_reset();
    run_cyc(1'b1, 8'h00, 16'h0400, 8'h99, fc0, fa0, rdy0, pulses, act_n, lastce, sa, sh, sw, swd, rd);
    chk(rdy0 == 1'b1 && act_n == 0, "R1 shadow cleared", {rdy0, act_n[0]}, 2'b10);
    run_cyc(1'b0, 8'h00, 16'h0300, 8'h00, fc0, fa0, rdy0, pulses, act_n, lastce, sa, sh, sw, swd, rd);
    chk(fa0 == 24'h000300, "R1 aux cleared", fa0, 24'h000300);
    run_cyc(1'b0, 8'h01, 16'hE000, 8'h00, fc0, fa0, rdy0, pulses, act_n, lastce, sa, sh, sw, swd, rd);
    chk(fa0 == 24'hFFE000, "R1 lc cleared", fa0, 24'hFFE000);

    cpu_req = 1'b0;
    finish_run();
  end
endmodule